// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

This block keeps the statistics counters for one Ethernet port. The receive MAC and the transmit MAC each give it at most one frame event per cycle. An event carries the frame length, a set of status flags and, for transmit, the number of collisions the frame met. The block sorts each frame into one of seven length bins. It counts every flagged condition. It adds the frame length into one of three 64-bit byte totals: receive good bytes, receive bad bytes and transmit bytes.

Software reads the counters as 32-bit words at fixed word offsets inside a per-port window. A read returns the counter and sets it to zero in the same access. A byte total appears as a low word followed by a high word. Reading the low word captures the high word into a snapshot, so a later high-word read sees a value that matches the low word it came with.

Reads use a valid/ready request channel and a valid/ready response channel. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. Once `req_valid` is raised, it and `req_addr` must stay unchanged until the request is accepted. There is a single response register. `req_ready` is low while that register holds a response the consumer has not yet taken. A pending response stays valid and unchanged until `resp_ready` is high. The frame event inputs have no back-pressure: every event is counted in the cycle it is presented.

Top module: `mib_stat_bank`

## Requirements
- R1: An accepted read of a counter word returns its value, and the counter is zero afterwards, so an immediate second read returns 0.
- R2: When a frame event increments a counter in the same cycle that a read of that counter is accepted, the read returns the old value and the counter then holds only the new increment.
- R3: The 32-bit counters (width CNT_W) saturate at all-ones and never wrap.
- R4: A receive frame with the good flag (rx_flags bit 0) set goes into exactly one bin, chosen by length: up to 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and above 1518. These bins are at word offsets 0x1C to 0x34 in that order. Bad frames go into no bin.
- R5: Every transmit frame goes into the same seven bins, at word offsets 0x64 to 0x7C.
- R6: A good receive frame adds its length to the good-byte total, whose low word is at 0x3C. A bad receive frame adds its length to the bad-byte total, whose low word is at 0x44. Every transmit frame adds its length to the transmit-byte total, whose low word is at 0x84. Each high word is at the low-word offset plus 4.
- R7: Reading a low word clears the whole byte total and captures its high half into a snapshot. A high-word read returns that snapshot and clears it, and the total is not affected.
- R8: Flag counters. rx_flags bits 1 to 10 are broadcast, multicast, pause, FCS error, alignment error, runt, fragment, too-long, overflow and filtered. They count at 0x00, 0x08, 0x04, 0x0C, 0x10, 0x14, 0x18, 0x38, 0x4C and 0x50. tx_flags bits 0 to 10 are broadcast, multicast, pause, underrun, oversize, abort-collision, multi-collision, single-collision, excessive-defer, defer and late-collision. They count at 0x54, 0x5C, 0x58, 0x60, 0x80, 0x90, 0x94, 0x98, 0x9C, 0xA0 and 0xA4.
- R9: The port window begins at WIN_BASE + PORT_IDX*WIN_STRIDE. A read outside it, at an address that is not word aligned, or past offset 0xA4 returns 0 and clears nothing.
- R10: After a read is accepted, the response is valid on the next cycle. A response that is not taken keeps its data stable and holds req_ready low.
- R11: After reset every counter, total and snapshot reads 0, resp_valid is low and req_ready is high.
- R12: The collision counter at 0x8C adds the value of tx_coll_cnt for each transmit frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive frame event strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flags | input | 11 | Receive status flags (bit 0 good, see R8) |
| tx_valid | input | 1 | Transmit frame event strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 11 | Transmit status flags (see R8) |
| tx_coll_cnt | input | COLL_W | Collisions seen by this transmit frame |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the word to read |
| resp_valid | output | 1 | Read response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | 32 | Read data, zero-extended counter value |

## Verification
The assertions assume that `req_valid` and `req_addr` stay unchanged from the time a request is raised until it is accepted. They also assume `rx_len` fits in LEN_W bits, and that the byte totals stay small enough that the monotonic checks on the 32-bit counters never run into a wrap of a 64-bit total. The stimulus raises each request only after it sees `req_ready` high at the inactive clock edge, and it drops the request right after acceptance. Frame lengths stay below 16384, collision counts stay at 15 or less, and the bench narrows CNT_W so that saturation and the carry into a high word can be reached in a few thousand frames.

// File: rtl/mib_pkg.sv
package mib_pkg;
  localparam int NUM_WORDS = 42;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_BINS  = 7;
  localparam int FLAG_W    = 11;

  // receive flag bit positions
  localparam int RXF_GOOD = 0;

  // word indices whose position is fixed by the decoding side
  localparam int W_RX_BIN0    = 7;
  localparam int W_RX_GOOD_LO = 15;
  localparam int W_RX_BAD_LO  = 17;
  localparam int W_TX_BIN0    = 25;
  localparam int W_TX_BYTE_LO = 33;
  localparam int W_TX_COLL    = 35;

  // upper edge of length bin b (last bin is open)
  function automatic int bin_top(int b);
    case (b)
      0: return 64;
      1: return 127;
      2: return 255;
      3: return 511;
      4: return 1023;
      default: return 1518;
    endcase
  endfunction

  function automatic int pair_lo_word(int p);
    case (p)
      0: return W_RX_GOOD_LO;
      1: return W_RX_BAD_LO;
      default: return W_TX_BYTE_LO;
    endcase
  endfunction

  function automatic bit is_pair_lo(int w);
    return (w == W_RX_GOOD_LO) || (w == W_RX_BAD_LO) || (w == W_TX_BYTE_LO);
  endfunction

  function automatic bit is_pair_hi(int w);
    return is_pair_lo(w - 1);
  endfunction

  function automatic int pair_idx(int w);
    if (w == W_RX_BAD_LO || w == W_RX_BAD_LO + 1) return 1;
    if (w == W_TX_BYTE_LO || w == W_TX_BYTE_LO + 1) return 2;
    return 0;
  endfunction

  // word counted by receive flag f (f >= 1)
  function automatic int rx_flag_word(int f);
    case (f)
      1: return 0;   // broadcast
      2: return 2;   // multicast
      3: return 1;   // pause
      4: return 3;   // fcs error
      5: return 4;   // alignment error
      6: return 5;   // runt
      7: return 6;   // fragment
      8: return 14;  // too long
      9: return 19;  // overflow
      default: return 20; // filtered
    endcase
  endfunction

  // word counted by transmit flag f
  function automatic int tx_flag_word(int f);
    case (f)
      0: return 21;  // broadcast
      1: return 23;  // multicast
      2: return 22;  // pause
      3: return 24;  // underrun
      4: return 32;  // oversize
      5: return 36;  // abort collision
      6: return 37;  // multiple collision
      7: return 38;  // single collision
      8: return 39;  // excessive defer
      9: return 40;  // defer
      default: return 41; // late collision
    endcase
  endfunction
endpackage

// File: rtl/mib_len_binner.sv
module mib_len_binner
  import mib_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic                valid,
  input  logic [LEN_W-1:0]    len,
  output logic [NUM_BINS-1:0] bin
);
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    localparam int LO = (b == 0) ? 0 : bin_top(b - 1) + 1;
    localparam int HI = bin_top(b);
    if (b == NUM_BINS - 1) begin : g_open
      assign bin[b] = valid && (int'(len) >= LO);
    end else begin : g_closed
      assign bin[b] = valid && (int'(len) >= LO) && (int'(len) <= HI);
    end
  end
endmodule

// File: rtl/mib_sat_counter.sv
module mib_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] amt,
  input  logic             clr,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, q} + (CNT_W + 1)'(amt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= CNT_W'(amt);
    else if (sum[CNT_W]) q <= '1;
    else                 q <= sum[CNT_W-1:0];
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1 && !clr) |=> (q == '1));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q >= $past(q)));
endmodule

// File: rtl/mib_wide_acc.sv
module mib_wide_acc #(
  parameter int ACC_W = 64,
  parameter int ADD_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add,
  input  logic             clr,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= ACC_W'(add);
    else          acc <= acc + ACC_W'(add);
  end

  p_clear_keeps_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc <= ACC_W'({ADD_W{1'b1}})));
endmodule

// File: rtl/mib_read_port.sv
module mib_read_port
  import mib_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 18,
  parameter int unsigned WIN_BASE   = 32'h20000,
  parameter int unsigned WIN_STRIDE = 256,
  parameter int          PORT_IDX   = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic [DATA_W-1:0]    resp_data,
  input  logic [CNT_W-1:0]     cnt_val [NUM_WORDS],
  input  logic [CNT_W-1:0]     acc_hi  [NUM_PAIRS],
  output logic [NUM_WORDS-1:0] clr_word
);
  localparam int          OFS_W    = $clog2(WIN_STRIDE);
  localparam int unsigned WIN_ADDR = WIN_BASE + WIN_STRIDE * PORT_IDX;
  localparam logic [ADDR_W-1:0] WIN_VEC = ADDR_W'(WIN_ADDR);

  logic [OFS_W-3:0]     word_idx;
  logic                 hit, accept;
  logic [CNT_W-1:0]     rd_val;
  logic [CNT_W-1:0]     snap [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] snap_set, snap_clr;

  assign word_idx  = req_addr[OFS_W-1:2];
  assign hit       = (req_addr[ADDR_W-1:OFS_W] == WIN_VEC[ADDR_W-1:OFS_W]) &&
                     (req_addr[1:0] == 2'b00) && (int'(word_idx) < NUM_WORDS);
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    rd_val   = '0;
    clr_word = '0;
    snap_set = '0;
    snap_clr = '0;
    if (accept && hit) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(word_idx) == w) begin
          if (is_pair_hi(w)) begin
            rd_val = snap[pair_idx(w)];
            snap_clr[pair_idx(w)] = 1'b1;
          end else begin
            rd_val = cnt_val[w];
            clr_word[w] = 1'b1;
            if (is_pair_lo(w)) snap_set[pair_idx(w)] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      for (int p = 0; p < NUM_PAIRS; p++) snap[p] <= '0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_data  <= DATA_W'(rd_val);
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (snap_set[p])      snap[p] <= acc_hi[p];
        else if (snap_clr[p]) snap[p] <= '0;
      end
    end
  end

  p_resp_follows_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);

  p_resp_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  p_single_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_word));

  p_miss_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |-> (clr_word == '0 && snap_clr == '0));
endmodule

// File: rtl/mib_stat_bank.sv
module mib_stat_bank
  import mib_pkg::*;
#(
  parameter int          PORT_IDX   = 0,
  parameter int unsigned WIN_BASE   = 32'h20000,
  parameter int unsigned WIN_STRIDE = 256,
  parameter int          ADDR_W     = 18,
  parameter int          CNT_W      = 32,
  parameter int          LEN_W      = 14,
  parameter int          COLL_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [10:0]       rx_flags,
  input  logic              tx_valid,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [10:0]       tx_flags,
  input  logic [COLL_W-1:0] tx_coll_cnt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_data
);
  localparam int ACC_W  = 2 * CNT_W;
  localparam int INC_W  = COLL_W;
  localparam int DATA_W = 32;

  logic [INC_W-1:0]     inc_amt  [NUM_WORDS];
  logic [CNT_W-1:0]     cnt_val  [NUM_WORDS];
  logic [CNT_W-1:0]     acc_hi   [NUM_PAIRS];
  logic [LEN_W-1:0]     pair_add [NUM_PAIRS];
  logic [NUM_WORDS-1:0] clr_word;
  logic [NUM_BINS-1:0]  rx_bin, tx_bin;
  logic                 rx_good;

  assign rx_good = rx_valid && rx_flags[RXF_GOOD];

  mib_len_binner #(.LEN_W(LEN_W)) i_rx_binner (
    .valid(rx_good), .len(rx_len), .bin(rx_bin));

  mib_len_binner #(.LEN_W(LEN_W)) i_tx_binner (
    .valid(tx_valid), .len(tx_len), .bin(tx_bin));

  // increment amounts for every counter word
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) inc_amt[w] = '0;
    for (int f = 1; f < FLAG_W; f++)
      inc_amt[rx_flag_word(f)][0] = rx_valid && rx_flags[f];
    for (int f = 0; f < FLAG_W; f++)
      inc_amt[tx_flag_word(f)][0] = tx_valid && tx_flags[f];
    for (int b = 0; b < NUM_BINS; b++) begin
      inc_amt[W_RX_BIN0 + b][0] = rx_bin[b];
      inc_amt[W_TX_BIN0 + b][0] = tx_bin[b];
    end
    inc_amt[W_TX_COLL] = tx_valid ? tx_coll_cnt : '0;
  end

  assign pair_add[0] = rx_good ? rx_len : '0;
  assign pair_add[1] = (rx_valid && !rx_flags[RXF_GOOD]) ? rx_len : '0;
  assign pair_add[2] = tx_valid ? tx_len : '0;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (!is_pair_lo(w) && !is_pair_hi(w)) begin : g_cnt
      mib_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .amt(inc_amt[w]),
        .clr(clr_word[w]), .q(cnt_val[w]));
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [ACC_W-1:0] acc;
    mib_wide_acc #(.ACC_W(ACC_W), .ADD_W(LEN_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .add(pair_add[p]),
      .clr(clr_word[pair_lo_word(p)]), .acc(acc));
    assign cnt_val[pair_lo_word(p)]     = acc[CNT_W-1:0];
    assign cnt_val[pair_lo_word(p) + 1] = acc[ACC_W-1:CNT_W];
    assign acc_hi[p]                    = acc[ACC_W-1:CNT_W];
  end

  // high-word clear strobes are never raised: a high read only drains the snapshot
  logic unused_hi_clr;
  assign unused_hi_clr = clr_word[W_RX_GOOD_LO + 1] | clr_word[W_RX_BAD_LO + 1] |
                         clr_word[W_TX_BYTE_LO + 1];

  mib_read_port #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
    .WIN_STRIDE(WIN_STRIDE), .PORT_IDX(PORT_IDX)
  ) i_read_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .cnt_val(cnt_val), .acc_hi(acc_hi), .clr_word(clr_word));

  p_one_rx_bin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_good |-> ($countones(rx_bin) == 1));

  p_bad_no_bin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_good |-> (rx_bin == '0));

  p_one_tx_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($countones(tx_bin) == 1));
endmodule

// File: tb/test_mib_stat_bank.sv
`timescale 1ns/1ps
module test_mib_stat_bank;
  localparam int CW   = 16;
  localparam int PIDX = 2;
  localparam int unsigned BASE = 32'h20000 + 32'h100 * PIDX;
  localparam longint unsigned CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_valid = 1'b0;
  logic [13:0] rx_len = '0, tx_len = '0;
  logic [10:0] rx_flags = '0, tx_flags = '0;
  logic [3:0]  tx_coll_cnt = '0;
  logic req_valid = 1'b0, resp_ready = 1'b1;
  logic req_ready, resp_valid;
  logic [17:0] req_addr = '0;
  logic [31:0] resp_data;

  always #4 clk = ~clk;

  mib_stat_bank #(.PORT_IDX(PIDX), .CNT_W(CW)) i_mib_stat_bank (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_len(rx_len),
    .rx_flags(rx_flags), .tx_valid(tx_valid), .tx_len(tx_len),
    .tx_flags(tx_flags), .tx_coll_cnt(tx_coll_cnt), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  longint unsigned exp_q[$];
  string tag_q[$];

  // reference model built from the requirements
  longint unsigned m_cnt [42];
  longint unsigned m_acc [3];
  longint unsigned m_snap [3];
  int rx_word [11] = '{-1, 0, 2, 1, 3, 4, 5, 6, 14, 19, 20};
  int tx_word [11] = '{21, 23, 22, 24, 32, 36, 37, 38, 39, 40, 41};
  int lo_word [3]  = '{15, 17, 33};

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int bin_of(int len);
    if (len <= 64) return 0;
    if (len <= 127) return 1;
    if (len <= 255) return 2;
    if (len <= 511) return 3;
    if (len <= 1023) return 4;
    if (len <= 1518) return 5;
    return 6;
  endfunction

  function automatic void bump(int w, longint unsigned n);
    m_cnt[w] = (m_cnt[w] + n > CMAX) ? CMAX : m_cnt[w] + n;
  endfunction

  function automatic void rx_model(int len, logic [10:0] f);
    if (f[0]) begin bump(7 + bin_of(len), 1); m_acc[0] += len; end
    else m_acc[1] += len;
    for (int i = 1; i < 11; i++) if (f[i]) bump(rx_word[i], 1);
    m_acc[0] &= 64'hFFFF_FFFF; m_acc[1] &= 64'hFFFF_FFFF;
  endfunction

  function automatic void tx_model(int len, logic [10:0] f, int coll);
    bump(25 + bin_of(len), 1);
    m_acc[2] = (m_acc[2] + len) & 64'hFFFF_FFFF;
    for (int i = 0; i < 11; i++) if (f[i]) bump(tx_word[i], 1);
    bump(35, coll);
  endfunction

  function automatic longint unsigned model_read(int w);
    longint unsigned r;
    for (int p = 0; p < 3; p++) begin
      if (w == lo_word[p] + 1) begin r = m_snap[p]; m_snap[p] = 0; return r; end
      if (w == lo_word[p]) begin
        r = m_acc[p] & CMAX; m_snap[p] = m_acc[p] >> CW; m_acc[p] = 0; return r;
      end
    end
    r = m_cnt[w]; m_cnt[w] = 0; return r;
  endfunction

  function automatic logic [17:0] addr_of(int w);
    return 18'(BASE + 4 * w);
  endfunction

  // driver: request with the expected response pushed into the scoreboard
  task automatic issue(logic [17:0] a, longint unsigned e, string t);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(int w, string t);
    issue(addr_of(w), model_read(w), t);
  endtask

  task automatic rx_frame(int len, logic [10:0] f);
    @(negedge clk);
    rx_valid = 1'b1; rx_len = 14'(len); rx_flags = f; rx_model(len, f);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_frame(int len, logic [10:0] f, int coll);
    @(negedge clk);
    tx_valid = 1'b1; tx_len = 14'(len); tx_flags = f; tx_coll_cnt = 4'(coll);
    tx_model(len, f, coll);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on every response handshake
  always @(negedge clk) begin
    #1;
    if (rst_n && resp_valid && resp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected response actual=0x%0h expected=none", resp_data);
      end else begin
        longint unsigned e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, resp_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lens [13] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9000};
    for (int w = 0; w < 42; w++) m_cnt[w] = 0;
    for (int p = 0; p < 3; p++) begin m_acc[p] = 0; m_snap[p] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 req_ready after reset", req_ready, 1);
    check("R11 resp_valid after reset", resp_valid, 0);
    for (int w = 0; w < 42; w++) rd(w, "R11 word zero after reset");

    // receive length bins and byte totals
    foreach (lens[i]) rx_frame(lens[i], 11'h001);
    rx_frame(100, 11'h000);
    rx_frame(40, 11'h040);
    for (int b = 0; b < 7; b++) rd(7 + b, "R4 rx length bin");
    rd(15, "R6 rx good bytes low");
    rd(16, "R7 rx good bytes high");
    rd(17, "R6 rx bad bytes low");

    // transmit bins, bytes and collisions
    foreach (lens[i]) tx_frame(lens[i], 11'h000, i % 16);
    for (int b = 0; b < 7; b++) rd(25 + b, "R5 tx length bin");
    rd(33, "R6 tx bytes low");
    rd(35, "R12 tx collision sum");

    // every flag counter at its offset
    for (int i = 1; i < 11; i++) rx_frame(70, 11'(1 << i) | 11'h001);
    for (int i = 0; i < 11; i++) tx_frame(70, 11'(1 << i), 0);
    for (int i = 1; i < 11; i++) rd(rx_word[i], "R8 rx flag counter");
    for (int i = 0; i < 11; i++) rd(tx_word[i], "R8 tx flag counter");
    rd(7, "R4 rx bin after flags");
    rd(25, "R5 tx bin after flags");

    // clear on read
    rx_frame(80, 11'h003);
    rd(0, "R1 first read");
    rd(0, "R1 second read is zero");

    // carry into the high word, snapshot coherence
    rd(15, "R7 drain good bytes");
    repeat (5) rx_frame(16000, 11'h001);
    rd(15, "R7 low word with carry");
    rx_frame(16000, 11'h001);
    rd(16, "R7 snapshot high word");
    rd(16, "R7 snapshot cleared");
    rd(15, "R7 total restarted");
    rd(13, "R4 open bin count");

    // increment and read of the same counter in one cycle
    rx_frame(90, 11'h002);
    rx_frame(90, 11'h002);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr_of(0);
    exp_q.push_back(model_read(0)); tag_q.push_back("R2 read returns old value");
    rx_valid = 1'b1; rx_len = 14'd90; rx_flags = 11'h002; rx_model(90, 11'h002);
    @(negedge clk);
    req_valid = 1'b0; rx_valid = 1'b0;
    rd(0, "R2 counter holds new increment");

    // window decode
    rx_frame(90, 11'h002);
    issue(18'h20000, 0, "R9 other port window");
    issue(18'(BASE + 1), 0, "R9 unaligned address");
    issue(18'(BASE + 4 * 42), 0, "R9 past last word");
    rd(0, "R9 counter untouched by misses");

    // back-pressure on the response
    tx_frame(300, 11'h001, 0);
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_addr = addr_of(21);
    exp_q.push_back(model_read(21)); tag_q.push_back("R10 stalled response data");
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10 response held", resp_valid, 1);
      check("R10 request blocked", req_ready, 0);
      check("R10 data stable", resp_data, 1);
    end
    resp_ready = 1'b1;
    rd(21, "R10 cleared after stall");

    // saturation of a counter
    rd(35, "R3 drain collisions");
    for (int i = 0; i < 4400; i++) tx_frame(64, 11'h000, 15);
    rd(35, "R3 saturated collision counter");
    rd(25, "R5 bin after long run");

    repeat (6) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule